// File: doc/BRIEF.md
# Transmit Timestamp Capture Queue

This block sits beside an outbound packet path and records the 64-bit time at which each packet that asked for a timestamp was sent. The transmit path presents a capture strobe together with the descriptor's timestamp-request bit, which is bit 47 of the outbound descriptor word. The block samples the free-running time value into a four-entry first-in first-out store only when both are high.

Software works through a small register port. It sees the oldest pending timestamp on a read bus, and a write to the release select drops that entry. A second select sets a 4-bit threshold, a third sets the local interrupt enable, and a fourth clears the sticky overflow flag. The block reports how many entries are pending and how many are free. It raises a flag when the pending count rises above the threshold, and that flag reaches the interrupt output only when the enable is set.

Top module: `tx_tstamp_queue`

## Requirements
- R1: After reset the pending count is 0, the available count is 4, the read data is 0, the threshold is 15, the enable is 0, and the flag, interrupt and overflow outputs are 0.
- R2: A capture happens only on a clock edge where `capValid` and `tsReqBit` (descriptor bit 47) are both 1. It stores `timeNow` from that edge, and the count reflects it after that edge.
- R3: The queue depth is 4, and `pendCnt + availCnt` equals 4 at all times.
- R4: `tsData` shows the oldest pending timestamp. A write with `regSel` = 0 (release) removes it, so entries leave in capture order.
- R5: A release write while `pendCnt` is 0 is ignored. Counts, read data and flags are unchanged.
- R6: A write with `regSel` = 1 loads the threshold from `regWdata[3:0]`. `tsFlag` is 1 exactly when `pendCnt` > threshold. A write with `regSel` = 2 loads the enable from `regWdata[0]`, and `tsIrq` is `tsFlag` AND enable.
- R7: A capture that arrives while the queue is full, with no release in the same cycle, is dropped and sets `ovfFlag`. The flag stays 1 until a write with `regSel` = 3 and `regWdata[0]` = 1 clears it. If a capture and the clear fall in the same cycle, the set wins.
- R8: A capture and a release in the same cycle with `pendCnt` ≥ 1 leave `pendCnt` unchanged and keep capture order, even when the queue is full. A full queue in that case does not set overflow.
- R9: While the queue is empty, `tsData` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capValid | input | 1 | Packet-sent strobe from the transmit path |
| tsReqBit | input | 1 | Descriptor bit 47, the timestamp request |
| timeNow | input | 64 | Current time value |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Write select: 0 release, 1 threshold, 2 enable, 3 overflow clear |
| regWdata | input | 4 | Write data |
| tsData | output | 64 | Oldest pending timestamp, 0 when empty |
| pendCnt | output | 3 | Pending entries |
| availCnt | output | 3 | Free entries |
| tsFlag | output | 1 | Pending count above threshold |
| tsIrq | output | 1 | Enabled timestamp interrupt |
| ovfFlag | output | 1 | Sticky dropped-capture flag |

## Verification
Capture and release can fall on the same edge, and the bench drives both strobes for a single cycle to provoke this. It does so in three states: a queue holding one entry, a full queue, and an empty queue where the release must be ignored. In each case the result is judged from the pending count, the overflow flag and the order in which timestamps drain on the read bus, checked against values kept in the bench.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  // Strobes from control to storage for one clock edge.
  typedef struct packed {
    logic push;
    logic pop;
  } tsq_strb_t;
endpackage

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
  import tsq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int THR_W = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   capHit,
  input  logic                                   relReq,
  input  logic                                   thrWr,
  input  logic                                   enWr,
  input  logic                                   ovfClr,
  input  logic [THR_W-1:0]                       wrVal,
  output tsq_strb_t                              strb,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] wrIdx,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rdIdx,
  output logic [$clog2(DEPTH+1)-1:0]             pendCnt,
  output logic [$clog2(DEPTH+1)-1:0]             availCnt,
  output logic                                   tsFlag,
  output logic                                   tsIrq,
  output logic                                   ovfFlag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic             isFull, isEmpty;
  logic [THR_W-1:0] thrReg;
  logic             intEn;

  assign isFull  = (pendCnt == CNT_W'(DEPTH));
  assign isEmpty = (pendCnt == '0);

  // A release is effective only when something is pending; a capture
  // fits when there is room or a slot frees in the same cycle.
  always_comb begin
    strb.pop  = relReq && !isEmpty;
    strb.push = capHit && (!isFull || strb.pop);
  end

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx   <= '0;
      rdIdx   <= '0;
      pendCnt <= '0;
      ovfFlag <= 1'b0;
      thrReg  <= '1;
      intEn   <= 1'b0;
    end else begin
      if (strb.push) wrIdx <= nextPtr(wrIdx);
      if (strb.pop)  rdIdx <= nextPtr(rdIdx);
      case ({strb.push, strb.pop})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
      if (capHit && !strb.push) ovfFlag <= 1'b1;
      else if (ovfClr)          ovfFlag <= 1'b0;
      if (thrWr) thrReg <= wrVal;
      if (enWr)  intEn  <= wrVal[0];
    end
  end

  assign availCnt = CNT_W'(DEPTH) - pendCnt;
  assign tsFlag   = CMP_W'(pendCnt) > CMP_W'(thrReg);
  assign tsIrq    = tsFlag && intEn;

  // R3: occupancy never exceeds the depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= CNT_W'(DEPTH));

  // R5: release on empty with no capture leaves the queue empty
  p_empty_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (relReq && isEmpty && !capHit) |=> (pendCnt == '0));

  // R7: capture into a full queue without release is dropped and flagged
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (capHit && isFull && !relReq) |=> (ovfFlag && pendCnt == CNT_W'(DEPTH)));

  // R8: simultaneous capture and release on a non-empty queue keeps the count
  p_simul_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (capHit && relReq && !isEmpty) |=> $stable(pendCnt));
endmodule

// File: rtl/tsq_store.sv
module tsq_store
  import tsq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TS_W  = 64
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  tsq_strb_t                              strb,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] wrIdx,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rdIdx,
  input  logic                                   hasData,
  input  logic [TS_W-1:0]                        tsIn,
  output logic [TS_W-1:0]                        tsOut
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [TS_W-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN)                                   slot[i] <= '0;
      else if (strb.push && wrIdx == PTR_W'(i))    slot[i] <= tsIn;
    end
  end

  assign tsOut = hasData ? slot[rdIdx] : '0;

  // R2: a push lands the sampled time in the addressed slot
  p_push_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> (slot[$past(wrIdx)] == $past(tsIn)));
endmodule

// File: rtl/tx_tstamp_queue.sv
module tx_tstamp_queue
  import tsq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TS_W  = 64,
  parameter int THR_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       capValid,
  input  logic                       tsReqBit,
  input  logic [TS_W-1:0]            timeNow,
  input  logic                       regWrEn,
  input  logic [1:0]                 regSel,
  input  logic [THR_W-1:0]           regWdata,
  output logic [TS_W-1:0]            tsData,
  output logic [$clog2(DEPTH+1)-1:0] pendCnt,
  output logic [$clog2(DEPTH+1)-1:0] availCnt,
  output logic                       tsFlag,
  output logic                       tsIrq,
  output logic                       ovfFlag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  tsq_strb_t        strb;
  logic [PTR_W-1:0] wrIdx, rdIdx;
  logic             capHit, relReq, thrWr, enWr, ovfClr;

  assign capHit = capValid && tsReqBit;
  assign relReq = regWrEn && (regSel == 2'd0);
  assign thrWr  = regWrEn && (regSel == 2'd1);
  assign enWr   = regWrEn && (regSel == 2'd2);
  assign ovfClr = regWrEn && (regSel == 2'd3) && regWdata[0];

  tsq_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .capHit(capHit), .relReq(relReq),
    .thrWr(thrWr), .enWr(enWr), .ovfClr(ovfClr), .wrVal(regWdata),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx), .pendCnt(pendCnt),
    .availCnt(availCnt), .tsFlag(tsFlag), .tsIrq(tsIrq), .ovfFlag(ovfFlag)
  );

  tsq_store #(.DEPTH(DEPTH), .TS_W(TS_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .hasData(pendCnt != '0), .tsIn(timeNow), .tsOut(tsData)
  );
endmodule

// File: tb/tx_tstamp_queue_tb.sv
module tx_tstamp_queue_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capValid = 1'b0, tsReqBit = 1'b0;
  logic [63:0] timeNow = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [3:0]  regWdata = '0;
  logic [63:0] tsData;
  logic [2:0]  pendCnt, availCnt;
  logic        tsFlag, tsIrq, ovfFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  tx_tstamp_queue u_dut (
    .clk(clk), .rstN(rstN), .capValid(capValid), .tsReqBit(tsReqBit),
    .timeNow(timeNow), .regWrEn(regWrEn), .regSel(regSel), .regWdata(regWdata),
    .tsData(tsData), .pendCnt(pendCnt), .availCnt(availCnt),
    .tsFlag(tsFlag), .tsIrq(tsIrq), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    capValid = 1'b0; tsReqBit = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic cap(input logic [63:0] t, input logic bit47);
    capValid = 1'b1; tsReqBit = bit47; timeNow = t;
    step();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] d);
    regWrEn = 1'b1; regSel = sel; regWdata = d;
    step();
  endtask

  task automatic chkCounts(input string req, input int p);
    chk(req, 64'(pendCnt), 64'(p));
    chk({req, "_sum_R3"}, 64'(pendCnt) + 64'(availCnt), 64'd4);
  endtask

  task automatic t_reset();
    chkCounts("R1_pend", 0);
    chk("R1_avail", 64'(availCnt), 64'd4);
    chk("R1_data_R9", tsData, 64'd0);
    chk("R1_flags", {61'd0, tsFlag, tsIrq, ovfFlag}, 64'd0);
  endtask

  task automatic t_filter();
    cap(64'hAAAA, 1'b0);
    chkCounts("R2_nobit", 0);
    tsReqBit = 1'b1; timeNow = 64'hBBBB; step();
    chkCounts("R2_nostrobe", 0);
    cap(64'h1234_5678_9ABC_DEF0, 1'b1);
    chkCounts("R2_cap", 1);
    chk("R2_value", tsData, 64'h1234_5678_9ABC_DEF0);
    wr(2'd0, 4'd0);
    chk("R9_empty", tsData, 64'd0);
  endtask

  task automatic t_fifo();
    cap(64'h11, 1'b1); cap(64'h22, 1'b1); cap(64'h33, 1'b1);
    chkCounts("R4_three", 3);
    chk("R4_head0", tsData, 64'h11); wr(2'd0, 4'd0);
    chk("R4_head1", tsData, 64'h22); wr(2'd0, 4'd0);
    chk("R4_head2", tsData, 64'h33); wr(2'd0, 4'd0);
    chkCounts("R4_drained", 0);
  endtask

  task automatic t_empty_release();
    wr(2'd0, 4'd0); wr(2'd0, 4'd0);
    chkCounts("R5_pend", 0);
    chk("R5_data", tsData, 64'd0);
    cap(64'h44, 1'b1);
    chk("R5_after", tsData, 64'h44);
    chkCounts("R5_after_cnt", 1);
    // Capture and release together on an empty queue: release ignored.
    wr(2'd0, 4'd0);
    capValid = 1'b1; tsReqBit = 1'b1; timeNow = 64'h55;
    regWrEn = 1'b1; regSel = 2'd0; step();
    chkCounts("R5_R8_emptysim", 1);
    chk("R5_R8_emptyval", tsData, 64'h55);
    wr(2'd0, 4'd0);
  endtask

  task automatic t_threshold();
    wr(2'd1, 4'd1);
    cap(64'h1, 1'b1);
    chk("R6_flag_eq", 64'(tsFlag), 64'd0);
    cap(64'h2, 1'b1);
    chk("R6_flag_gt", 64'(tsFlag), 64'd1);
    chk("R6_irq_off", 64'(tsIrq), 64'd0);
    wr(2'd2, 4'd1);
    chk("R6_irq_on", 64'(tsIrq), 64'd1);
    wr(2'd1, 4'd2);
    chk("R6_flag_raise", {62'd0, tsFlag, tsIrq}, 64'd0);
    wr(2'd1, 4'd0);
    wr(2'd0, 4'd0);
    chk("R6_flag_one", 64'(tsFlag), 64'd1);
    wr(2'd0, 4'd0);
    chk("R6_flag_zero", 64'(tsFlag), 64'd0);
    wr(2'd2, 4'd0); wr(2'd1, 4'd15);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 4; i++) cap(64'(16'hA0 + i), 1'b1);
    chkCounts("R7_full", 4);
    chk("R7_avail0", 64'(availCnt), 64'd0);
    cap(64'hDEAD, 1'b1);
    chkCounts("R7_drop", 4);
    chk("R7_ovf", 64'(ovfFlag), 64'd1);
    for (int i = 0; i < 4; i++) begin
      chk("R7_order", tsData, 64'(16'hA0 + i));
      wr(2'd0, 4'd0);
    end
    chk("R7_sticky", 64'(ovfFlag), 64'd1);
    wr(2'd3, 4'd0);
    chk("R7_noclr", 64'(ovfFlag), 64'd1);
    wr(2'd3, 4'd1);
    chk("R7_clr", 64'(ovfFlag), 64'd0);
  endtask

  task automatic t_simul();
    cap(64'hC0, 1'b1);
    capValid = 1'b1; tsReqBit = 1'b1; timeNow = 64'hC1;
    regWrEn = 1'b1; regSel = 2'd0; step();
    chkCounts("R8_one", 1);
    chk("R8_one_val", tsData, 64'hC1);
    cap(64'hC2, 1'b1); cap(64'hC3, 1'b1); cap(64'hC4, 1'b1);
    chkCounts("R8_full", 4);
    capValid = 1'b1; tsReqBit = 1'b1; timeNow = 64'hC5;
    regWrEn = 1'b1; regSel = 2'd0; step();
    chkCounts("R8_fullsim", 4);
    chk("R8_noovf", 64'(ovfFlag), 64'd0);
    for (int i = 2; i < 6; i++) begin
      chk("R8_order", tsData, 64'(8'hC0 + i));
      wr(2'd0, 4'd0);
    end
    chkCounts("R8_drained", 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_filter();
    t_fifo();
    t_empty_release();
    t_threshold();
    t_overflow();
    t_simul();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule